// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single read and write transactions on a two-wire PHY management bus: a management clock and one shared data line. A client raises a request together with a direction flag, a 5-bit PHY address, a 5-bit register number and, for writes, a 16-bit word. The block then shifts out a complete frame bit by bit. For reads, it collects the sixteen bits that the PHY returns and presents them on a result port with a one-cycle completion pulse.

The management clock comes from the system clock. Each bit-time has two halves of `HALF_CYC` system cycles each. In the low half the data output and its enable are updated. At the end of the high half the data input is sampled. The tristate pad, bus-side registers and any software access sit outside the block. The block only provides the output level, the output enable and the input.

Top module: `mdio_master`

## Requirements
- R1: While reset (`rst_ni` low, asynchronous) is applied, and whenever no frame is in progress, `mdc_o`, `mdio_o`, `mdio_oe_o`, `busy_o` and `done_o` are all 0.
- R2: A request (`req_i` high) is taken only in a cycle where `busy_o` is 0, and `busy_o` rises at that clock edge. Direction (`rd_i`=1 read), addresses and write data are captured at that edge. Changes to those inputs, and requests made while `busy_o` is 1, have no effect on the frame in progress.
- R3: Bit-times 0 to 31 of every frame drive a 1 with the output enabled.
- R4: Bit-times 32 and 33 drive 0 then 1. Bit-times 34 and 35 drive 1,0 for a read and 0,1 for a write. All four are driven with the output enabled.
- R5: Bit-times 36 to 40 drive the PHY address and 41 to 45 drive the register number, both most significant bit first, with the output enabled.
- R6: A read frame is 64 bit-times long. Bit-time 46 is released. In bit-times 47 to 62 the input is sampled, and these bits form the result most significant bit first. Bit-time 63 is released.
- R7: A write frame is 65 bit-times long. Bit-times 46 and 47 are released. Bit-times 48 to 63 drive the write word most significant bit first, with the output enabled. Bit-time 64 is released. A released bit-time has `mdio_oe_o`=0 and `mdio_o`=0.
- R8: Each bit-time is `HALF_CYC` cycles with `mdc_o`=0 followed by `HALF_CYC` cycles with `mdc_o`=1. `mdio_o` and `mdio_oe_o` change only at the start of a low half. `mdio_i` is sampled in the last cycle of the high half.
- R9: In the cycle after the final high half, `busy_o` is 0 and `done_o` is 1 for exactly one cycle. This happens for both reads and writes.
- R10: `rdata_o` is loaded only at the end of a read frame and keeps its value across write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transaction |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register number |
| wdata_i | input | 16 | Write word |
| mdio_i | input | 1 | Data line input |
| busy_o | output | 1 | Frame in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output level |
| mdio_oe_o | output | 1 | Data line output enable |
| rdata_o | output | 16 | Last read result |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
A wrong bit counter or a field captured at the wrong time shows up as a mismatch at the data pins in the very bit-time it affects. The bench compares every bit-time of every frame against a frame built from the requirements, so such a fault is reported within `2*HALF_CYC` cycles. The bench also gives the input a wrong value for the first part of each high half and the correct value only in its last cycle. Sampling in the wrong cycle therefore corrupts the result, and this appears on `rdata_o` at the completion pulse. Sweeps cover all PHY addresses on reads and all register numbers on writes, plus disturbance of the request inputs during a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = 7;
  localparam int PRE_LEN  = 32;
  localparam int HDR_BEG  = PRE_LEN + 4;          // first address bit-time
  localparam int HDR_END  = HDR_BEG + 2*ADDR_W;   // first bit-time after header
  localparam int RD_DBEG  = HDR_END + 1;
  localparam int WR_DBEG  = HDR_END + 2;
  localparam int RD_LAST  = RD_DBEG + DATA_W;     // released final bit-time
  localparam int WR_LAST  = WR_DBEG + DATA_W;
endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
  parameter int HALF_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic half_end_o
);
  if (HALF_CYC <= 1) begin : g_direct
    assign half_end_o = run_i;
  end else begin : g_count
    localparam int CNT_W = $clog2(HALF_CYC);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HALF_CYC - 1);
    logic [CNT_W-1:0] cnt_q;

    assign half_end_o = run_i && (cnt_q == CNT_MAX);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= '0;
      else if (!run_i)     cnt_q <= '0;
      else if (half_end_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end

    a_r8_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_MAX);
    a_r8_cnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> cnt_q == '0);
  end
endmodule

// File: rtl/mdio_frame_enc.sv
module mdio_frame_enc
  import mdio_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              smp_o,
  output logic              last_o
);
  logic [2*ADDR_W-1:0] hdr;
  logic [3:0]          hk;
  logic [3:0]          dk;
  logic [IDX_W-1:0]    hoff;
  logic [IDX_W-1:0]    doff;

  assign hdr  = {phy_i, reg_i};
  assign hoff = idx_i - IDX_W'(HDR_BEG);
  assign doff = idx_i - IDX_W'(rd_i ? RD_DBEG : WR_DBEG);
  assign hk   = hoff[3:0];
  assign dk   = doff[3:0];

  always_comb begin
    mdo_o  = 1'b0;
    oe_o   = 1'b0;
    smp_o  = 1'b0;
    last_o = rd_i ? (idx_i == IDX_W'(RD_LAST)) : (idx_i == IDX_W'(WR_LAST));
    if (idx_i < IDX_W'(PRE_LEN)) begin
      mdo_o = 1'b1;
      oe_o  = 1'b1;
    end else if (idx_i < IDX_W'(PRE_LEN + 2)) begin
      oe_o  = 1'b1;
      mdo_o = idx_i[0];                    // start: 0 then 1
    end else if (idx_i < IDX_W'(HDR_BEG)) begin
      oe_o  = 1'b1;
      mdo_o = rd_i ^ idx_i[0];             // read 1,0 / write 0,1
    end else if (idx_i < IDX_W'(HDR_END)) begin
      oe_o  = 1'b1;
      mdo_o = hdr[4'(2*ADDR_W-1) - hk];
    end else if (idx_i >= IDX_W'(rd_i ? RD_DBEG : WR_DBEG) &&
                 idx_i <  IDX_W'(rd_i ? RD_LAST : WR_LAST)) begin
      if (rd_i) smp_o = 1'b1;
      else begin
        oe_o  = 1'b1;
        mdo_o = wdata_i[4'(DATA_W-1) - dk];
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 2500
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  logic              busy_q, phase_hi_q, done_q, rd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] wd_q, shreg_q, rdata_q;
  logic              half_end, enc_mdo, enc_oe, enc_smp, enc_last, frame_end;

  mdio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(busy_q), .half_end_o(half_end)
  );

  mdio_frame_enc u_enc (
    .idx_i(idx_q), .rd_i(rd_q), .phy_i(phy_q), .reg_i(reg_q), .wdata_i(wd_q),
    .mdo_o(enc_mdo), .oe_o(enc_oe), .smp_o(enc_smp), .last_o(enc_last)
  );

  assign frame_end = half_end && phase_hi_q && enc_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; phase_hi_q <= 1'b0; done_q <= 1'b0; rd_q <= 1'b0;
      idx_q <= '0; phy_q <= '0; reg_q <= '0; wd_q <= '0;
      shreg_q <= '0; rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q <= 1'b1; phase_hi_q <= 1'b0; idx_q <= '0;
          rd_q <= rd_i; phy_q <= phy_addr_i; reg_q <= reg_addr_i; wd_q <= wdata_i;
        end
      end else if (half_end) begin
        phase_hi_q <= ~phase_hi_q;
        if (phase_hi_q) begin
          if (enc_smp) shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
          if (enc_last) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (rd_q) rdata_q <= shreg_q;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdc_o     = busy_q && phase_hi_q;
  assign mdio_o    = busy_q && enc_mdo;
  assign mdio_oe_o = busy_q && enc_oe;
  assign rdata_o   = rdata_q;
  assign done_o    = done_q;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o && !mdio_o && !mdio_oe_o);
  a_r2_fields_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !frame_end |=> $stable({rd_q, phy_q, reg_q, wd_q}));
  a_r6_r7_idx_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> idx_q <= IDX_W'(rd_q ? RD_LAST : WR_LAST));
  a_r8_mdc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !half_end |=> $stable(mdc_o));
  a_r8_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(half_end && phase_hi_q) |=> $stable(mdio_o) && $stable(mdio_oe_o));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_end && rd_q) |=> $stable(rdata_o));
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int H = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, rd_i = 1'b0, mdio_i = 1'b0;
  logic [4:0] phy_addr_i = '0, reg_addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic busy_o, mdc_o, mdio_o, mdio_oe_o, done_o;
  logic [15:0] rdata_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master #(.HALF_CYC(H)) u0 (
    .clk_i(clk), .rst_ni, .req_i, .rd_i, .phy_addr_i, .reg_addr_i, .wdata_i,
    .mdio_i, .busy_o, .mdc_o, .mdio_o, .mdio_oe_o, .rdata_o, .done_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  // {oe, mdo} per bit-time, from R3..R7
  function automatic logic [1:0] exp_bit(int k, bit rd, logic [4:0] pa,
                                         logic [4:0] ra, logic [15:0] wd);
    if (k < 32)  return 2'b11;                    // R3
    if (k == 32) return 2'b10;                    // R4
    if (k == 33) return 2'b11;
    if (k == 34) return {1'b1, rd};
    if (k == 35) return {1'b1, ~rd};
    if (k < 41)  return {1'b1, pa[40-k]};         // R5
    if (k < 46)  return {1'b1, ra[45-k]};
    if (rd)      return 2'b00;                    // R6
    if (k < 48)  return 2'b00;                    // R7
    if (k < 64)  return {1'b1, wd[63-k]};
    return 2'b00;
  endfunction

  task automatic run_frame(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input logic [15:0] phy_data,
                           input bit disturb);
    int len;
    logic [1:0] e;
    logic b;
    len = rd ? 64 : 65;
    @(negedge clk);
    check(busy_o == 1'b0, "R2 idle before request", busy_o, 0);
    req_i = 1'b1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(negedge clk);
    check(busy_o == 1'b1, "R2 busy after accept", busy_o, 1);
    if (disturb) begin
      rd_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;  // R2 ignored
    end else req_i = 1'b0;
    for (int k = 0; k < len; k++) begin
      e = exp_bit(k, rd, pa, ra, wd);
      b = (rd && k >= 47 && k <= 62) ? phy_data[62-k] : k[0];
      mdio_i = ~b;
      if (disturb && k == 10) req_i = 1'b0;
      check(mdc_o == 1'b0 && busy_o == 1'b1, "R8 low half", {mdc_o, busy_o}, 2'b01);
      check({mdio_oe_o, mdio_o} == e, $sformatf("R3-7 bit %0d low", k),
            {mdio_oe_o, mdio_o}, e);
      repeat (H) @(negedge clk);
      check(mdc_o == 1'b1, "R8 high half", mdc_o, 1);
      check({mdio_oe_o, mdio_o} == e, $sformatf("R8 bit %0d held high", k),
            {mdio_oe_o, mdio_o}, e);
      repeat (H-1) @(negedge clk);
      mdio_i = b;                                  // R8 sample in last high cycle
      @(negedge clk);
    end
    check(busy_o == 1'b0 && done_o == 1'b1, "R9 end pulse", {busy_o, done_o}, 2'b01);
    check({mdc_o, mdio_o, mdio_oe_o} == 3'b000, "R1 idle after frame",
          {mdc_o, mdio_o, mdio_oe_o}, 0);
    if (rd) begin
      check(rdata_o == phy_data, "R6 read result", rdata_o, phy_data);
      last_rd = phy_data;
    end else begin
      check(rdata_o == last_rd, "R10 rdata kept over write", rdata_o, last_rd);
    end
    @(negedge clk);
    check(done_o == 1'b0, "R9 single pulse", done_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy_o, mdc_o, mdio_o, mdio_oe_o, done_o} == 5'b0, "R1 in reset",
          {busy_o, mdc_o, mdio_o, mdio_oe_o, done_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check({busy_o, mdc_o, mdio_o, mdio_oe_o, done_o} == 5'b0, "R1 after reset",
          {busy_o, mdc_o, mdio_o, mdio_oe_o, done_o}, 0);
    check(rdata_o == 16'h0, "R10 rdata reset", rdata_o, 0);
    for (int a = 0; a < 32; a++)
      run_frame(1'b1, 5'(a), 5'(31 - a), 16'h0, 16'((a * 16'h0841) ^ 16'hA55A), 1'b0);
    for (int r = 0; r < 32; r++)
      run_frame(1'b0, 5'(r ^ 5'h15), 5'(r), 16'((r * 16'h1357) ^ 16'h8001), 16'h0, 1'b0);
    run_frame(1'b1, 5'h1F, 5'h1F, 16'h0, 16'hFFFF, 1'b0);
    run_frame(1'b1, 5'h00, 5'h00, 16'h0, 16'h0000, 1'b0);
    run_frame(1'b0, 5'h00, 5'h00, 16'hFFFF, 16'h0, 1'b0);
    run_frame(1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h0, 1'b0);
    run_frame(1'b1, 5'h0A, 5'h12, 16'h0, 16'h8001, 1'b1);   // R2 disturbed read
    run_frame(1'b0, 5'h05, 5'h04, 16'h6C3B, 16'h0, 1'b1);   // R2 disturbed write
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R2 no stray accept", busy_o, 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule